// File: doc/BRIEF.md
# Fast Address Step Unit (16-bit increment/decrement)

This block moves an address-sized value up or down by exactly one, with no clock and no stored state. A processor places it beside the main arithmetic unit so that the program counter can advance during sequential fetch and the stack pointer can move on push and pop, all without taking the ALU away from user arithmetic. A single select input chooses between stepping up and stepping down, and the result appears as soon as the logic settles.

The carry (or borrow) does not travel bit by bit across all sixteen positions. The operand is cut into 4-bit groups. Inside each group, every bit's carry is formed directly from the group's carry-in and the lower bits of that group. Between groups, a mux chain passes the carry over any group whose bits all propagate. A further output shows whether the operand is exactly 0x0001. Loop control logic uses it to see that a block-move count is about to run out.

Top module: `incdec_unit`

## Requirements
- R1: With `mode_dec_i` = 0 (step up), `result_o` equals (`operand_i` + 1) mod 65536 for every operand value.
- R2: With `mode_dec_i` = 1 (step down), `result_o` equals (`operand_i` − 1) mod 65536 for every operand value.
- R3: `wrap_o` is 1 exactly when the step crosses the 16-bit boundary: step up of 0xFFFF (giving 0x0000) or step down of 0x0000 (giving 0xFFFF). Otherwise it is 0.
- R4: `is_one_o` is 1 exactly when `operand_i` equals 0x0001, whichever way `mode_dec_i` is set.
- R5: The unit is purely combinational. All outputs follow a change on the inputs within the same clock cycle of the surrounding design, with no register stage.
- R6: Bit 0 of `result_o` is always the inverse of bit 0 of `operand_i`.
- R7: When the lowest 4-bit group does not propagate (step up with operand bits [3:0] not all 1, or step down with them not all 0), `result_o[15:4]` equals `operand_i[15:4]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand_i | input | 16 | Value to be stepped |
| mode_dec_i | input | 1 | 0 = step up by one, 1 = step down by one |
| result_o | output | 16 | Stepped value, modulo 2^16 |
| wrap_o | output | 1 | Carry or borrow out of bit 15 |
| is_one_o | output | 1 | Operand equals 0x0001 |

## Verification
The hardest case to reach is a carry that has to skip several whole groups at once, such as 0x0FFF or 0xFFFF stepping up and 0x1000 or 0x0000 stepping down. Only a few of the 65536 operands per mode make the skip chain pass a carry through three or four groups. The bench puts these boundary operands in a directed list first. It then sweeps every operand value in both modes, so each skip-chain path and each in-group lookahead term is driven at least once and compared with a reference computed independently.

// File: rtl/incdec_pkg.sv
// Package: shared parameters and encodings for the address step unit.
// Assumes the datapath width is an integer multiple of the group width.
package incdec_pkg;
    parameter int unsigned ADDR_W = 16;
    parameter int unsigned GRP_W  = 4;

    // Direction select encoding on mode_dec_i.
    typedef enum logic {
        STEP_UP   = 1'b0,
        STEP_DOWN = 1'b1
    } step_dir_e;
endpackage

// File: rtl/incdec_group.sv
// Module: one lookahead group of the step unit.
// Each bit's carry is formed directly from the group carry-in and the
// propagate terms of the lower bits in this group, not passed bit by bit.
// A bit propagates when it is 1 on a step up or 0 on a step down.
// Assumes the carry-in is 1 only when every lower group propagates.
module incdec_group #(
    parameter int unsigned GW = incdec_pkg::GRP_W
) (
    input  logic [GW-1:0] bits_i,
    input  logic          down_i,
    input  logic          cin_i,
    output logic [GW-1:0] sum_o,
    output logic          prop_o
);
    logic [GW-1:0] prop_bit;
    logic [GW-1:0] carry_bit;

    // Per-bit propagate: depends on the step direction.
    always_comb begin
        for (int i = 0; i < GW; i++) begin
            prop_bit[i] = down_i ? ~bits_i[i] : bits_i[i];
        end
    end

    // Lookahead: carry into bit i is the wide AND of the carry-in and the lower propagates.
    genvar i;
    generate
        for (i = 0; i < GW; i++) begin : g_la
            if (i == 0) begin : g_first
                assign carry_bit[i] = cin_i;
            end else begin : g_rest
                assign carry_bit[i] = cin_i & (&prop_bit[i-1:0]);
            end
        end
    endgenerate

    // Sum and group-propagate outputs.
    always_comb begin
        sum_o  = bits_i ^ carry_bit;
        prop_o = &prop_bit;
    end
endmodule

// File: rtl/incdec_skip.sv
// Module: inter-group skip chain.
// Group 0 always receives the injected +/-1 as its carry-in. Every later
// group's carry-in comes through a mux that passes the previous carry-in
// only when the previous group propagates as a whole. There are one mux
// level per group, not one per bit.
module incdec_skip #(
    parameter int unsigned NGRP = 4
) (
    input  logic [NGRP-1:0] gprop_i,
    output logic [NGRP-1:0] gcin_o,
    output logic            cout_o
);
    genvar g;
    generate
        for (g = 0; g < NGRP; g++) begin : g_skip
            if (g == 0) begin : g_inject
                assign gcin_o[g] = 1'b1;
            end else begin : g_bypass
                assign gcin_o[g] = gprop_i[g-1] ? gcin_o[g-1] : 1'b0;
            end
        end
    endgenerate

    // Carry out of the top group is the wrap indication.
    assign cout_o = gprop_i[NGRP-1] ? gcin_o[NGRP-1] : 1'b0;
endmodule

// File: rtl/incdec_one_det.sv
// Module: detects an operand equal to exactly one.
// Each upper group reports all-zero and the low group is matched against 1.
// The result does not depend on the step direction.
module incdec_one_det #(
    parameter int unsigned W  = incdec_pkg::ADDR_W,
    parameter int unsigned GW = incdec_pkg::GRP_W
) (
    input  logic [W-1:0] value_i,
    output logic         is_one_o
);
    localparam int unsigned NGRP = W / GW;

    logic [NGRP-1:0] grp_ok;

    genvar g;
    generate
        for (g = 0; g < NGRP; g++) begin : g_det
            if (g == 0) begin : g_low
                assign grp_ok[g] = (value_i[GW-1:0] == GW'(1));
            end else begin : g_high
                assign grp_ok[g] = ~|value_i[g*GW +: GW];
            end
        end
    endgenerate

    // All groups must match their pattern.
    assign is_one_o = &grp_ok;
endmodule

// File: rtl/incdec_unit.sv
// Module: top of the 16-bit address step unit.
// Purely combinational. It has no clock and no reset, so it assumes the
// surrounding pipeline registers its inputs and outputs.
// The groups are built with generate, and the carries between them come from the skip chain.
module incdec_unit #(
    parameter int unsigned WIDTH = incdec_pkg::ADDR_W,
    parameter int unsigned GW    = incdec_pkg::GRP_W
) (
    input  logic [WIDTH-1:0] operand_i,
    input  logic             mode_dec_i,
    output logic [WIDTH-1:0] result_o,
    output logic             wrap_o,
    output logic             is_one_o
);
    localparam int unsigned NGRP = WIDTH / GW;

    logic [NGRP-1:0] grp_prop;
    logic [NGRP-1:0] grp_cin;
    logic            down;

    // Direction decode from the select pin.
    assign down = (incdec_pkg::step_dir_e'(mode_dec_i) == incdec_pkg::STEP_DOWN);

    genvar g;
    generate
        for (g = 0; g < NGRP; g++) begin : g_grp
            incdec_group #(.GW(GW)) u_grp (
                .bits_i (operand_i[g*GW +: GW]),
                .down_i (down),
                .cin_i  (grp_cin[g]),
                .sum_o  (result_o[g*GW +: GW]),
                .prop_o (grp_prop[g])
            );
        end
    endgenerate

    incdec_skip #(.NGRP(NGRP)) u_skip (
        .gprop_i (grp_prop),
        .gcin_o  (grp_cin),
        .cout_o  (wrap_o)
    );

    incdec_one_det #(.W(WIDTH), .GW(GW)) u_one (
        .value_i  (operand_i),
        .is_one_o (is_one_o)
    );
endmodule

// File: rtl/incdec_unit_chk.sv
// Checker: relates the step unit's outputs to its inputs.
// The unit has no clock, so these are immediate checks that are evaluated
// whenever the ports settle.
module incdec_unit_chk #(
    parameter int unsigned WIDTH = 16,
    parameter int unsigned GW    = 4
) (
    input logic [WIDTH-1:0] operand_i,
    input logic             mode_dec_i,
    input logic [WIDTH-1:0] result_o,
    input logic             wrap_o,
    input logic             is_one_o
);
    logic [WIDTH:0] ref_up;
    logic [WIDTH:0] ref_dn;
    logic           low_prop;

    // Reference arithmetic and low-group propagate, computed independently.
    always_comb begin
        ref_up   = {1'b0, operand_i} + (WIDTH+1)'(1);
        ref_dn   = {1'b0, operand_i} - (WIDTH+1)'(1);
        low_prop = mode_dec_i ? (operand_i[GW-1:0] == '0) : (operand_i[GW-1:0] == '1);
    end

    // Property checks on settled values.
    always_comb begin
        if (!mode_dec_i) AST_STEP_UP: assert (result_o == ref_up[WIDTH-1:0]);   // R1
        if (mode_dec_i) AST_STEP_DOWN: assert (result_o == ref_dn[WIDTH-1:0]);  // R2
        AST_WRAP_EDGE: assert (wrap_o == (mode_dec_i ? ref_dn[WIDTH] : ref_up[WIDTH])); // R3
        AST_ONE_FLAG: assert (is_one_o == (operand_i == WIDTH'(1)));            // R4
        AST_LSB_TOGGLE: assert (result_o[0] != operand_i[0]);                   // R6
        if (!low_prop) AST_UPPER_HOLD: assert (result_o[WIDTH-1:GW] == operand_i[WIDTH-1:GW]); // R7
    end
endmodule

bind incdec_unit incdec_unit_chk #(.WIDTH(WIDTH), .GW(GW)) u_chk (
    .operand_i  (operand_i),
    .mode_dec_i (mode_dec_i),
    .result_o   (result_o),
    .wrap_o     (wrap_o),
    .is_one_o   (is_one_o)
);

// File: tb/tb_incdec_unit.sv
// Bench: scoreboard for the step unit. A driver task applies an operand
// just after a rising edge and queues the expected outputs. A monitor pops
// the queue at the following falling edge and compares the values.
`timescale 1ns/1ps
module tb_incdec_unit;
    typedef struct {
        logic [15:0] op;
        logic        dn;
        logic [15:0] exp_res;
        logic        exp_wrap;
        logic        exp_one;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] operand = 16'h0000;
    logic        mode_dec = 1'b0;
    logic [15:0] result;
    logic        wrap;
    logic        is_one;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    item_t q[$];

    // 200 MHz clock.
    always #2.5 clk = ~clk;

    incdec_unit dut (
        .operand_i  (operand),
        .mode_dec_i (mode_dec),
        .result_o   (result),
        .wrap_o     (wrap),
        .is_one_o   (is_one)
    );

    // Driver: apply one operand and queue its expected outputs.
    task automatic drive(input int v, input bit dn);
        item_t it;
        @(posedge clk);
        #1;
        operand  = v[15:0];
        mode_dec = dn;
        it.op       = v[15:0];
        it.dn       = dn;
        it.exp_res  = dn ? 16'((v + 65535) % 65536) : 16'((v + 1) % 65536);
        it.exp_wrap = dn ? (v == 0) : (v == 65535);
        it.exp_one  = (v == 1);
        q.push_back(it);
    endtask

    // Monitor: compare the settled outputs in the same cycle (R5: no register stage).
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                checks++;
                if (result !== it.exp_res) begin
                    failures++;
                    $display("FAIL %s op=%h result actual=%h expected=%h",
                             it.dn ? "R2" : "R1", it.op, result, it.exp_res);
                end
                checks++;
                if (wrap !== it.exp_wrap) begin
                    failures++;
                    $display("FAIL R3 op=%h dn=%0d wrap actual=%0d expected=%0d",
                             it.op, it.dn, wrap, it.exp_wrap);
                end
                checks++;
                if (is_one !== it.exp_one) begin
                    failures++;
                    $display("FAIL R4 op=%h dn=%0d is_one actual=%0d expected=%0d",
                             it.op, it.dn, is_one, it.exp_one);
                end
                checks++;
                if (result[0] === it.op[0]) begin
                    failures++;
                    $display("FAIL R6 op=%h bit0 actual=%0d expected=%0d",
                             it.op, result[0], ~it.op[0]);
                end
                if (it.dn ? (it.op[3:0] != 4'h0) : (it.op[3:0] != 4'hF)) begin
                    checks++;
                    if (result[15:4] !== it.op[15:4]) begin
                        failures++;
                        $display("FAIL R7 op=%h upper actual=%h expected=%h",
                                 it.op, result[15:4], it.op[15:4]);
                    end
                end
            end
        end
    end

    // Stimulus: reset, directed corners, then an exhaustive sweep in both modes.
    initial begin
        repeat (4) @(posedge clk);
        rst_n = 1'b1;
        // Reset state: default inputs give 0x0001, no wrap, no is_one (R1, R3, R4).
        drive(16'h0000, 1'b0);
        // R3 boundary wraps and multi-group skips.
        drive(16'hFFFF, 1'b0);
        drive(16'h0000, 1'b1);
        drive(16'h0FFF, 1'b0);
        drive(16'h1000, 1'b1);
        drive(16'h00FF, 1'b0);
        drive(16'h0100, 1'b1);
        // R4: one detector in both modes, and near misses.
        drive(16'h0001, 1'b0);
        drive(16'h0001, 1'b1);
        drive(16'h1001, 1'b0);
        drive(16'h0002, 1'b1);
        // R7: low group stops the carry.
        drive(16'hABC7, 1'b0);
        drive(16'hABC7, 1'b1);
        // R1 and R2 exhaustive sweep.
        for (int m = 0; m < 2; m++) begin
            for (int v = 0; v < 65536; v++) begin
                drive(v, m[0]);
            end
        end
        wait (q.size() == 0);
        @(posedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: end a hung run as a failure.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule